// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts one pulse-width request into two gate enables for a synchronous step-down stage: one for the high-side switch and one for the low-side switch. The two enables are never on together. Each switching edge uses its own guard. When the high side is about to turn on, the sequencer drops the low-side enable and then waits on a digital sense bit that reports the low-side gate has really discharged. There is no time limit on this wait. When the high side turns off, the low side comes back on only after a fixed number of clock cycles in which both enables are low.

A supervisor can override the sequencer with three inputs: undervoltage lockout, shutdown and a latched overvoltage fault. Any one of them drives the stage to its safe state, with the low side fully on and the high side off. This state lasts as long as the input is held. The same input also clears the dead-time timer. When all three inputs are released, the sequencer resumes with the low side on. The high side can then be reached only through a new sensed hand-over.

Top module: `gate_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with no request, the high-side enable is 0 and the low-side enable is 1.
- R2: The high-side and low-side enables are never both 1 in the same cycle.
- R3: The high-side enable rises only in the cycle after a clock edge at which the low-side enable was already 0 and the sense input was 1. While the sense input stays 0 it remains low for any number of cycles.
- R4: With no override active and the low side on, a request of 1 sampled at a clock edge makes the low-side enable 0 in the following cycle.
- R5: A request of 0 sampled while the high side is on makes the high-side enable 0 in the next cycle. The low-side enable then rises after exactly DEAD_CYCLES cycles in which both enables are 0.
- R6: If the request is 0 at an edge while the sequencer is waiting for the sense bit, the pending high-side turn-on is dropped and the low-side enable is 1 in the next cycle.
- R7: Undervoltage lockout high at an edge gives high-side 0 and low-side 1 in the next cycle, and this holds for every cycle it stays high.
- R8: Shutdown high at an edge gives high-side 0 and low-side 1 in the next cycle, and this holds for every cycle it stays high.
- R9: The overvoltage latch high at an edge gives high-side 0 and low-side 1 in the next cycle, so the low side runs at full duty while the latch is held.
- R10: Any override clears the dead-time timer. If an override interrupts a dead interval, the next dead interval again lasts a full DEAD_CYCLES cycles.
- R11: When the overrides are released, the low-side enable stays 1 until a request arrives. The high side is reached only through the R3 hand-over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_req | input | 1 | Request for the high-side conduction phase |
| dl_off_sense | input | 1 | 1 when the low-side gate is sensed as discharged |
| uvlo | input | 1 | Undervoltage lockout override |
| shdn | input | 1 | Shutdown override |
| ovp_latch | input | 1 | Latched overvoltage override |
| dh_en | output | 1 | High-side gate enable |
| dl_en | output | 1 | Low-side gate enable |

## Verification
Two functions can act in the same cycle. An override can arrive in the middle of a dead interval or during the sense wait, and at that same edge the sequencer may be ending the dead count or taking the sensed hand-over. The bench provokes this with directed cases that assert an override in the second cycle of a dead interval and again on the sensed edge itself. A random phase then mixes rare overrides with request toggles and a sparse sense bit. Each case passes only if the override wins in the next cycle, and only if the following dead interval has its full length and no other.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

    typedef enum logic [2:0] {
        ST_LOW_ON   = 3'd0,
        ST_SENSE    = 3'd1,
        ST_HIGH_ON  = 3'd2,
        ST_DEAD     = 3'd3,
        ST_OVERRIDE = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic uvlo;
        logic shdn;
        logic ovp;
    } override_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    function automatic logic override_any(override_t o);
        return o.uvlo | o.shdn | o.ovp;
    endfunction

    function automatic gate_pair_t gates_for(seq_state_e s);
        gate_pair_t g;
        g.hi = (s == ST_HIGH_ON);
        g.lo = (s == ST_LOW_ON) || (s == ST_OVERRIDE);
        return g;
    endfunction

endpackage

// File: rtl/gseq_override_merge.sv
module gseq_override_merge
    import gseq_pkg::*;
(
    input  override_t ovr,
    output logic      force_lo
);
    always_comb force_lo = override_any(ovr);
endmodule

// File: rtl/gseq_dead_timer.sv
module gseq_dead_timer #(
    parameter int DEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb done = run && (cnt == LAST);
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwm_req,
    input  logic       sense_off,
    input  logic       force_lo,
    input  logic       timer_done,
    output seq_state_e state,
    output gate_pair_t gates
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        if (force_lo) begin
            nxt = ST_OVERRIDE;
        end else begin
            unique case (state)
                ST_LOW_ON:   if (pwm_req) nxt = ST_SENSE;
                ST_SENSE:    if (!pwm_req) nxt = ST_LOW_ON;
                             else if (sense_off) nxt = ST_HIGH_ON;
                ST_HIGH_ON:  if (!pwm_req) nxt = ST_DEAD;
                ST_DEAD:     if (timer_done) nxt = ST_LOW_ON;
                ST_OVERRIDE: nxt = ST_LOW_ON;
                default:     nxt = ST_OVERRIDE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOW_ON;
        else     state <= nxt;
    end

    always_comb gates = gates_for(state);
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
    import gseq_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_req,
    input  logic dl_off_sense,
    input  logic uvlo,
    input  logic shdn,
    input  logic ovp_latch,
    output logic dh_en,
    output logic dl_en
);
    override_t  ovr;
    logic       force_lo;
    logic       timer_done;
    logic       in_dead;
    seq_state_e state;
    gate_pair_t gates;

    always_comb begin
        ovr.uvlo = uvlo;
        ovr.shdn = shdn;
        ovr.ovp  = ovp_latch;
    end

    gseq_override_merge u_merge (
        .ovr      (ovr),
        .force_lo (force_lo)
    );

    always_comb in_dead = (state == ST_DEAD);

    gseq_dead_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (force_lo),
        .run   (in_dead),
        .done  (timer_done)
    );

    gseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwm_req    (pwm_req),
        .sense_off  (dl_off_sense),
        .force_lo   (force_lo),
        .timer_done (timer_done),
        .state      (state),
        .gates      (gates)
    );

    always_comb begin
        dh_en = gates.hi;
        dl_en = gates.lo;
    end
endmodule

// File: rtl/gseq_checker.sv
module gseq_checker #(
    parameter int DEAD_CYCLES = 4
) (
    input logic clk,
    input logic rst,
    input logic pwm_req,
    input logic dl_off_sense,
    input logic uvlo,
    input logic shdn,
    input logic ovp_latch,
    input logic dh_en,
    input logic dl_en
);
    logic force_any;
    int   gap;
    logic after_hi;

    always_comb force_any = uvlo || shdn || ovp_latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= 0;
            after_hi <= 1'b0;
        end else if (dh_en) begin
            gap      <= 0;
            after_hi <= 1'b1;
        end else if (!dl_en) begin
            if (gap < DEAD_CYCLES + 2) gap <= gap + 1;
        end else begin
            after_hi <= 1'b0;
        end
    end

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(dh_en && dl_en));

    a_r3_sensed_handover: assert property (@(posedge clk) disable iff (rst)
        $rose(dh_en) |-> ($past(dl_off_sense) && !$past(dl_en)));

    a_r7_uvlo_safe: assert property (@(posedge clk) disable iff (rst)
        uvlo |=> (dl_en && !dh_en));

    a_r8_shdn_safe: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (dl_en && !dh_en));

    a_r9_ovp_safe: assert property (@(posedge clk) disable iff (rst)
        ovp_latch |=> (dl_en && !dh_en));

    a_r5_dead_length: assert property (@(posedge clk) disable iff (rst)
        ($rose(dl_en) && after_hi && !$past(force_any)) |-> (gap == DEAD_CYCLES));

    a_r6_abandon: assert property (@(posedge clk) disable iff (rst)
        (!dh_en && !dl_en && !after_hi && !pwm_req && !force_any) |=> dl_en);
endmodule

bind gate_sequencer gseq_checker #(.DEAD_CYCLES(DEAD_CYCLES)) u_gseq_chk (
    .clk          (clk),
    .rst          (rst),
    .pwm_req      (pwm_req),
    .dl_off_sense (dl_off_sense),
    .uvlo         (uvlo),
    .shdn         (shdn),
    .ovp_latch    (ovp_latch),
    .dh_en        (dh_en),
    .dl_en        (dl_en)
);

// File: tb/gate_sequencer_bench.sv
module gate_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm = 1'b0, sense = 1'b0, uvlo = 1'b0, shdn = 1'b0, ovp = 1'b0;
    logic dh, dl;

    int checks = 0;
    int errors = 0;
    int m_mode = 0;
    int m_cnt  = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_sequencer #(.DEAD_CYCLES(D)) u_gate_sequencer (
        .clk(clk), .rst(rst), .pwm_req(pwm), .dl_off_sense(sense),
        .uvlo(uvlo), .shdn(shdn), .ovp_latch(ovp), .dh_en(dh), .dl_en(dl)
    );

    // modes: 0 low on, 1 waiting for sense, 2 high on, 3 dead, 4 override
    function automatic bit exp_hi(int m); return m == 2; endfunction
    function automatic bit exp_lo(int m); return (m == 0) || (m == 4); endfunction

    task automatic model_step();
        if (rst) begin
            m_mode = 0; m_cnt = 0;
        end else if (uvlo || shdn || ovp) begin
            m_mode = 4; m_cnt = 0;
        end else begin
            case (m_mode)
                0: if (pwm) m_mode = 1;
                1: if (!pwm) m_mode = 0; else if (sense) m_mode = 2;
                2: if (!pwm) begin m_mode = 3; m_cnt = 0; end
                3: if (m_cnt == D - 1) m_mode = 0; else m_cnt++;
                default: m_mode = 0;
            endcase
        end
    endtask

    task automatic check(string tag, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, dh, exp_hi(m_mode), "dh_en");
        check(tag, dl, exp_lo(m_mode), "dl_en");
        check("R2", dh & dl, 1'b0, "overlap");
    endtask

    // From low-on: request and sense to reach high-on
    task automatic go_high();
        pwm = 1; sense = 0; step("R4");
        check("R4", dl, 1'b0, "dl after request");
        sense = 1; step("R3");
        check("R3", dh, 1'b1, "dh after sense");
        sense = 0;
    endtask

    task automatic measure_dead(string tag);
        int n;
        pwm = 0; step(tag);
        check(tag, dh, 1'b0, "dh after request fall");
        n = 0;
        while (!dl && n < 3 * D) begin n++; step(tag); end
        check(tag, 1'(n == D), 1'b1, "dead length equals DEAD_CYCLES");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        step("R1"); step("R1");
        check("R1", dl, 1'b1, "dl in reset");
        rst = 0;
        step("R1");

        // R3: long wait without sense keeps high side off
        pwm = 1; sense = 0;
        for (int i = 0; i < 50; i++) step("R3");
        check("R3", dh, 1'b0, "dh held while sense low");
        sense = 1; step("R3");
        check("R3", dh, 1'b1, "dh after sense");
        sense = 0;

        // R5: exact dead interval
        measure_dead("R5");

        // R6: abandon pending turn-on
        pwm = 1; step("R6");
        pwm = 0; step("R6");
        check("R6", dl, 1'b1, "dl back after abandon");

        // R10: override in the middle of dead time, then a full interval
        go_high();
        pwm = 0; step("R10"); step("R10");
        uvlo = 1; step("R7");
        check("R7", dl, 1'b1, "uvlo low side");
        uvlo = 0; step("R11");
        check("R11", dh, 1'b0, "no high side after release");
        go_high();
        measure_dead("R10");

        // override at the sensed edge itself
        pwm = 1; step("R4");
        sense = 1; shdn = 1; step("R8");
        check("R8", dh, 1'b0, "shdn beats sense");
        for (int i = 0; i < 5; i++) step("R8");
        shdn = 0; sense = 0; step("R11");
        pwm = 1; step("R11");

        // R9: overvoltage holds low side at full duty
        ovp = 1; sense = 1;
        for (int i = 0; i < 20; i++) begin
            step("R9");
            check("R9", dl, 1'b1, "ovp low side");
        end
        ovp = 0; sense = 0; pwm = 0; step("R11");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            string tag;
            if (($urandom % 8) == 0) pwm = ~pwm;
            sense = (($urandom % 4) == 0);
            uvlo = (($urandom % 60) == 0);
            shdn = (($urandom % 60) == 0);
            ovp  = (($urandom % 60) == 0);
            if (uvlo) tag = "R7";
            else if (shdn) tag = "R8";
            else if (ovp) tag = "R9";
            else if (m_mode == 3) tag = "R5";
            else if (m_mode == 1) tag = "R3";
            else tag = "R2";
            step(tag);
        end
        uvlo = 0; shdn = 0; ovp = 0;

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule